// File: doc/BRIEF.md
# Qualified Performance Event Counter

This block holds a set of wide event counters, two by default, each with its own 32-bit event-select control word. Every cycle it receives a small per-cycle event count for each counter and the current privilege level. It qualifies that count and adds the result to the counter. Qualification can apply a threshold comparison, an inversion of that comparison, rising-edge detection and a privilege filter. One global enable gates all counters at once.

When a counter wraps, the block can latch a sticky interrupt request. It can also toggle an external monitor pin. Instead of toggling on a wrap, the pin can toggle on every increment. The pin path is registered, so the pin lags the counter by two clocks. Software reaches the control words and the counters through a simple word-wide register port. Reads return their data one cycle after the request.

Top module: `qual_evt_ctr`

## Requirements
- R1: After reset, every control word and counter reads as zero, and every interrupt request and monitor pin is low.
- R2: While a counter's threshold field (control bits 31:24) is zero and edge mode is off, the counter adds the full per-cycle event count in every cycle that counting is permitted.
- R3: While the threshold field is nonzero, the counter adds exactly one in a cycle whose event count is greater than or equal to the threshold. In any other cycle it adds nothing.
- R4: With the invert bit (control bit 23) set and a nonzero threshold, the counter adds one in each cycle whose event count is below the threshold.
- R5: With edge mode (control bit 18) set, the counter adds one only when the qualified condition goes from false to true. A run of back-to-back true cycles adds one. The condition is the threshold result when the threshold is nonzero, and "event count nonzero" when it is zero.
- R6: Counting is permitted at privilege level 0 only when control bit 17 is set. It is permitted at levels 1 to 3 only when control bit 16 is set.
- R7: Bit 22 of control word 0 enables or disables every counter at once. Bit 22 of any other control word has no effect on counting.
- R8: A counter wraps from all ones to zero modulo its width. If control bit 20 is set, a wrap sets that counter's interrupt request. The request stays set until software writes either word of that counter.
- R9: If control bit 19 is set, the monitor pin toggles once per cycle in which the counter increases. If it is clear, the pin toggles once per wrap. The pin changes two clocks after the clock edge that updates the counter.
- R10: A register write to a counter word takes priority over an increment in the same cycle. The written value is kept and that cycle's events are dropped.
- R11: Address map: address i holds control word i. Address N+2i holds bits 31:0 of counter i, and address N+2i+1 holds its upper bits, zero-extended. N is the number of counters. Read data and rd_valid appear one cycle after rd_en. Reserved control bit 21 always reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW (3) | Read address |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High the cycle after rd_en |
| evt_cnt | input | NCTR*EVW (8) | Per-cycle event count, EVW bits per counter, counter 0 in the low bits |
| priv_lvl | input | 2 | Current privilege level |
| irq | output | NCTR (2) | Sticky overflow interrupt request per counter |
| mon_pin | output | NCTR (2) | Monitor pin per counter |

## Verification
The bench uses the default parameters: two 40-bit counters with a 4-bit event count per cycle. A 4-bit count can exceed small thresholds, so threshold, inversion and multi-event raw counts can all be tested. With 40 bits, the overflow can be tested by preloading 0xFF_FFFF_FFFE through the two words and adding a count of 3, which wraps to exactly 1. Having a second counter makes it possible to show that its own enable bit does not matter and that the global bit gates it.

// File: rtl/evc_pkg.sv
package evc_pkg;
  // Event-select control word, MSB first.
  typedef struct packed {
    logic [7:0] thresh;    // 31:24
    logic       inv;       // 23
    logic       glb_en;    // 22 (meaningful in word 0 only)
    logic       rsvd;      // 21
    logic       irq_en;    // 20
    logic       pin_inc;   // 19
    logic       edge_det;  // 18
    logic       os_en;     // 17
    logic       usr_en;    // 16
    logic [7:0] qual_mask; // 15:8
    logic [7:0] evt_code;  // 7:0
  } evsel_t;

  localparam logic [31:0] RSVD_MASK = 32'h0020_0000;
endpackage

// File: rtl/evc_qual.sv
module evc_qual
  import evc_pkg::*;
#(
  parameter int EVW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  evsel_t         cfg,
  input  logic           run_en,
  input  logic [1:0]     priv,
  input  logic [EVW-1:0] evt,
  output logic [EVW-1:0] inc
);
  localparam int CW = (EVW > 8) ? EVW : 8;

  logic [CW-1:0] evt_x, thr_x;
  logic allow, thr_hit, cond, cond_q, prev_q;

  assign evt_x   = CW'(evt);
  assign thr_x   = CW'(cfg.thresh);
  assign allow   = run_en & ((priv == 2'd0) ? cfg.os_en : cfg.usr_en);
  assign thr_hit = (evt_x >= thr_x);
  assign cond    = (cfg.thresh == 8'd0) ? (evt != '0) : (thr_hit ^ cfg.inv);
  assign cond_q  = cond & allow;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cond_q;
  end

  always_comb begin
    if (!allow)                  inc = '0;
    else if (cfg.edge_det)       inc = (cond_q & ~prev_q) ? EVW'(1) : '0;
    else if (cfg.thresh == 8'd0) inc = evt;
    else                         inc = cond ? EVW'(1) : '0;
  end

  // R3 R5: threshold or edge mode never adds more than one
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.edge_det || cfg.thresh != 8'd0) |-> (inc <= EVW'(1)));
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int CTR_W      = 40,
  parameter int EVW        = 4,
  parameter int PIN_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVW-1:0]   inc,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [31:0]      wdata,
  input  logic             irq_en,
  input  logic             pin_inc,
  output logic [CTR_W-1:0] cnt,
  output logic             irq,
  output logic             pin
);
  localparam int HW = CTR_W - 32;

  logic [CTR_W:0] sum;
  logic ld, ovf, pulse, tgl;
  logic [PIN_STAGES-1:0] pipe;

  assign ld    = ld_lo | ld_hi;
  assign sum   = {1'b0, cnt} + {{(CTR_W + 1 - EVW){1'b0}}, inc};
  assign ovf   = sum[CTR_W] & ~ld;
  assign pulse = pin_inc ? ((inc != '0) & ~ld) : ovf;
  assign pin   = pipe[PIN_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (ld) begin
      if (ld_lo) cnt[31:0]      <= wdata;
      if (ld_hi) cnt[CTR_W-1:32] <= wdata[HW-1:0];
      irq <= 1'b0;
    end else begin
      cnt <= sum[CTR_W-1:0];
      if (ovf && irq_en) irq <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl  <= 1'b0;
      pipe <= '0;
    end else begin
      tgl  <= tgl ^ pulse;
      pipe <= {pipe[PIN_STAGES-2:0], tgl};
    end
  end

  // R8: request is sticky without a counter write
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !ld) |=> irq);
  // R8: a counter write clears the request
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> !irq);
  // R2: no increment and no write leaves the count unchanged
  ctr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inc == '0 && !ld) |=> $stable(cnt));
endmodule

// File: rtl/qual_evt_ctr.sv
module qual_evt_ctr
  import evc_pkg::*;
#(
  parameter int NCTR  = 2,
  parameter int CTR_W = 40,
  parameter int EVW   = 4,
  parameter int AW    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  output logic [31:0]         rd_data,
  output logic                rd_valid,
  input  logic [NCTR*EVW-1:0] evt_cnt,
  input  logic [1:0]          priv_lvl,
  output logic [NCTR-1:0]     irq,
  output logic [NCTR-1:0]     mon_pin
);
  evsel_t           sel_q [NCTR];
  logic [CTR_W-1:0] cnt   [NCTR];
  logic [31:0]      rd_next;

  for (genvar i = 0; i < NCTR; i++) begin : g_ch
    logic [EVW-1:0] inc;
    logic ld_lo, ld_hi;

    assign ld_lo = wr_en && (wr_addr == AW'(NCTR + 2*i));
    assign ld_hi = wr_en && (wr_addr == AW'(NCTR + 2*i + 1));

    always_ff @(posedge clk) begin
      if (rst) sel_q[i] <= '0;
      else if (wr_en && wr_addr == AW'(i)) sel_q[i] <= evsel_t'(wr_data & ~RSVD_MASK);
    end

    evc_qual #(.EVW(EVW)) u_qual (
      .clk(clk), .rst(rst), .cfg(sel_q[i]), .run_en(sel_q[0].glb_en),
      .priv(priv_lvl), .evt(evt_cnt[i*EVW +: EVW]), .inc(inc));

    evc_counter #(.CTR_W(CTR_W), .EVW(EVW)) u_ctr (
      .clk(clk), .rst(rst), .inc(inc), .ld_lo(ld_lo), .ld_hi(ld_hi),
      .wdata(wr_data), .irq_en(sel_q[i].irq_en), .pin_inc(sel_q[i].pin_inc),
      .cnt(cnt[i]), .irq(irq[i]), .pin(mon_pin[i]));

    // R7: global enable clear freezes every counter not being written
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (!sel_q[0].glb_en && !ld_lo && !ld_hi) |=> $stable(cnt[i]));
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCTR; i++) begin
      if (rd_addr == AW'(i))            rd_next = sel_q[i];
      if (rd_addr == AW'(NCTR + 2*i))   rd_next = cnt[i][31:0];
      if (rd_addr == AW'(NCTR + 2*i+1)) rd_next = 32'(cnt[i][CTR_W-1:32]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  // R11: read data is valid exactly one cycle after the request
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: tb/qual_evt_ctr_tb_top.sv
module qual_evt_ctr_tb_top;
  localparam int AW = 3;
  localparam logic [31:0] EN = 32'h0040_0000, OS = 32'h0002_0000, USR = 32'h0001_0000,
    INV = 32'h0080_0000, EDG = 32'h0004_0000, PC = 32'h0008_0000, IE = 32'h0010_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic rd_valid;
  logic [7:0] evt_cnt = '0;
  logic [1:0] priv_lvl = 2'd3;
  logic [1:0] irq, mon_pin;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  qual_evt_ctr dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .evt_cnt(evt_cnt), .priv_lvl(priv_lvl), .irq(irq), .mon_pin(mon_pin));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(rd_data, 32'hx, "R11 unexpected read");
      else chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_en = 1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic run(input int e0, input int e1, input int p, input int n);
    evt_cnt = {4'(e1), 4'(e0)}; priv_lvl = 2'(p);
    repeat (n) @(negedge clk);
    evt_cnt = '0; priv_lvl = 2'd3;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd(0, 0, "R1 sel0"); rd(2, 0, "R1 ctr0 lo"); rd(5, 0, "R1 ctr1 hi");
    chk({30'd0, irq}, 0, "R1 irq"); chk({30'd0, mon_pin}, 0, "R1 pin");
    // R11 reserved bit reads zero
    wr(1, 32'hFFFF_FFFF); rd(1, 32'hFFDF_FFFF, "R11 reserved bit"); wr(1, 0);
    // R2 raw count
    wr(0, EN | OS);
    run(3, 0, 0, 4);
    rd(2, 12, "R2 raw count");
    rd(4, 0, "R6 ctr1 no privilege bits");
    // R3 threshold
    wr(0, EN | OS | (32'd2 << 24)); wr(2, 0);
    run(1,0,0,1); run(2,0,0,1); run(3,0,0,1); run(5,0,0,1); run(0,0,0,1);
    rd(2, 3, "R3 threshold");
    // R4 invert
    wr(0, EN | OS | INV | (32'd2 << 24)); wr(2, 0);
    run(1,0,0,1); run(2,0,0,1); run(3,0,0,1); run(0,0,0,2);
    rd(2, 3, "R4 invert");
    // R5 edge
    wr(0, EN | OS | EDG | (32'd1 << 24)); wr(2, 0);
    run(1,0,0,2); run(0,0,0,1); run(1,0,0,1); run(0,0,0,1); run(1,0,0,3);
    rd(2, 3, "R5 edge");
    // R6 privilege
    wr(0, EN | USR); wr(2, 0);
    run(2,0,0,3);
    rd(2, 0, "R6 level 0 blocked");
    run(2,0,2,2);
    rd(2, 4, "R6 level 2 counted");
    // R7 global enable
    wr(0, 0); wr(1, EN | OS | USR);
    run(0,1,0,3);
    rd(4, 0, "R7 own enable ignored");
    wr(0, EN);
    run(0,1,0,3);
    rd(4, 3, "R7 global enable");
    // R8 overflow and interrupt
    wr(0, EN | OS | IE); wr(3, 32'hFF); wr(2, 32'hFFFF_FFFE);
    rd(3, 32'h0000_00FF, "R11 high word");
    run(3,0,0,1);
    chk({31'd0, irq[0]}, 1, "R8 irq set");
    rd(2, 1, "R8 wrap lo"); rd(3, 0, "R8 wrap hi");
    chk({31'd0, irq[0]}, 1, "R8 irq sticky");
    chk({31'd0, mon_pin[0]}, 1, "R9 pin toggled on wrap");
    wr(2, 0);
    chk({31'd0, irq[0]}, 0, "R8 irq cleared by write");
    chk({31'd0, irq[1]}, 0, "R8 other irq");
    // R9 pin per increment with lag
    wr(0, EN | OS | PC);
    repeat (3) @(negedge clk);
    run(1,0,0,1);
    chk({31'd0, mon_pin[0]}, 1, "R9 pin lag edge 1");
    @(negedge clk);
    chk({31'd0, mon_pin[0]}, 1, "R9 pin lag edge 2");
    @(negedge clk);
    chk({31'd0, mon_pin[0]}, 0, "R9 pin toggled");
    // R10 write priority
    wr(0, EN | OS);
    evt_cnt = 8'h05; priv_lvl = 2'd0;
    wr(2, 100);
    evt_cnt = '0; priv_lvl = 2'd3;
    rd(2, 100, "R10 write priority");

    repeat (4) @(negedge clk);
    chk(exp_q.size(), 0, "R11 pending reads");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule